// File: doc/BRIEF.md
# Stereo Volume Trim with Peak Hold

This block sits on a stereo stream of signed 24-bit samples after the decimation and high-pass stages. It scales each channel by its own 8-bit attenuation setting, using linear steps of 1/256. Setting 0 leaves the signal at unity gain, and each step above zero removes another 1/256 of the signal.

Alongside the volume path, each channel keeps a running maximum of the absolute input magnitude. This maximum is taken before the volume stage, so the attenuation setting has no influence on it. A read request with a channel select returns that channel's maximum one cycle later and clears the register as part of the same read. When a sample arrives in the same cycle as the clearing read, the register restarts from that sample's magnitude instead of from zero. The read still returns the value that was held before the read.

Top module: `stereo_gain_peak`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `rd_valid` are 0 after that edge, and both peak registers are zero. A read straight after reset returns 0.
- R2: `out_valid` is high for exactly the one cycle that follows each cycle in which `in_valid` is high, and is low otherwise.
- R3: Each output sample is floor((input × (256 − setting)) / 256), where the input and output are signed 24-bit and the shift is arithmetic, so negative inputs round toward minus infinity.
- R4: The left output uses only `vol_left` and the right output uses only `vol_right`.
- R5: A setting of 0 passes the input through unchanged. A setting of 255 gives floor(input/256).
- R6: A channel's peak register holds the largest absolute input magnitude accepted since the last clear. The volume setting does not change it.
- R7: The input code −2^23 produces a magnitude of 2^23 − 1, which is the largest value a 23-bit peak can hold.
- R8: With `rd_req` high, `rd_sel` = 0 selects left and `rd_sel` = 1 selects right. In the next cycle `rd_valid` is high and `rd_peak` holds the selected peak. The selected register is cleared, and the other channel's register is left unchanged.
- R9: If `in_valid` is high in the same cycle as a read of a channel, that channel's register reloads with the new sample's magnitude. The read returns the value held before that cycle.
- R10: While `in_valid` is low, `out_left` and `out_right` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample pair present this cycle |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| vol_left | input | 8 | Left attenuation setting, 0 = unity |
| vol_right | input | 8 | Right attenuation setting, 0 = unity |
| rd_req | input | 1 | Peak read request; clears the selected peak |
| rd_sel | input | 1 | Channel for the read: 0 left, 1 right |
| out_valid | output | 1 | Attenuated pair valid |
| out_left | output | 24 | Attenuated left sample |
| out_right | output | 24 | Attenuated right sample |
| rd_valid | output | 1 | Peak read result valid |
| rd_peak | output | 23 | Peak magnitude of the selected channel |

## Verification
The bench builds the block with its default parameters: 24-bit samples and 8-bit settings. With these values the full-range codes are reachable, including the most negative input that saturates the magnitude. The settings 0, 1, 128 and 255 can be applied to both positive and negative samples. Floor rounding of negative products, per-channel independence and clear-on-read can all be observed directly. The same-cycle collision between a sample and a clearing read can also be observed.

// File: rtl/stg_pkg.sv
// Package: shared channel indexing for the stereo volume/peak block.
// Assumes exactly two channels, left at index 0 and right at index 1.
package stg_pkg;
    localparam int NUM_CH = 2;
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/abs_sat_mag.sv
// Module: absolute magnitude of a signed sample, one bit narrower than the input.
// Assumes two's complement input; the most negative code saturates to the
// largest positive magnitude so the result always fits in W-1 bits.
module abs_sat_mag #(
    parameter int W = 24
) (
    input  logic [W-1:0] din,
    output logic [W-2:0] mag
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] negated;

    // Purpose: form the two's complement negation of the sample.
    always_comb begin
        negated = ~din + 1'b1;
    end

    // Purpose: choose the positive value, saturating the single overflow case.
    always_comb begin
        if (!din[W-1]) begin
            mag = din[W-2:0];
        end else if (din == MOST_NEG) begin
            mag = {(W-1){1'b1}};
        end else begin
            mag = negated[W-2:0];
        end
    end
endmodule

// File: rtl/peak_hold.sv
// Module: per-channel running maximum of sample magnitude with clear-on-read.
// Assumes clr is asserted for exactly the cycle of the read; a sample arriving
// in that same cycle becomes the new starting value instead of zero.
module peak_hold #(
    parameter int MW = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [MW-1:0] smp_mag,
    input  logic          clr,
    output logic [MW-1:0] peak
);
    logic bigger;

    // Purpose: compare the new magnitude against the held maximum.
    always_comb begin
        bigger = smp_mag > peak;
    end

    // Purpose: hold, grow, clear or reload the peak register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak <= '0;
        end else if (clr) begin
            peak <= smp_vld ? smp_mag : '0;
        end else if (smp_vld && bigger) begin
            peak <= smp_mag;
        end
    end
endmodule

// File: rtl/lin_atten.sv
// Module: registered linear attenuator, out = floor(in * (2^VW - vol) / 2^VW).
// Assumes vol = 0 is unity gain; the output register loads only on en and
// holds its value otherwise.
module lin_atten #(
    parameter int W  = 24,
    parameter int VW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] din,
    input  logic [VW-1:0]       vol,
    output logic signed [W-1:0] dout
);
    localparam int            PW   = W + VW + 2;
    localparam logic [VW:0]   FULL = (VW+1)'(1) << VW;

    logic [VW:0]          gain;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;

    // Purpose: turn the attenuation setting into a multiplier of 1..2^VW.
    always_comb begin
        gain = FULL - {1'b0, vol};
    end

    // Purpose: signed multiply followed by an arithmetic (flooring) shift.
    always_comb begin
        prod   = PW'(din) * $signed({1'b0, gain});
        scaled = prod >>> VW;
    end

    // Purpose: register the scaled sample when a new input is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (en) begin
            dout <= scaled[W-1:0];
        end
    end
endmodule

// File: rtl/stereo_gain_peak.sv
// Module: stereo volume trim with per-channel peak hold and clear-on-read port.
// Assumes samples are signed DATA_W-bit values and a read takes one cycle:
// rd_req/rd_sel in one cycle, rd_valid/rd_peak in the next.
module stereo_gain_peak #(
    parameter int DATA_W = 24,
    parameter int VOL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic [VOL_W-1:0]  vol_left,
    input  logic [VOL_W-1:0]  vol_right,
    input  logic              rd_req,
    input  logic              rd_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              rd_valid,
    output logic [DATA_W-2:0] rd_peak
);
    import stg_pkg::*;

    localparam int MAG_W = DATA_W - 1;

    logic [DATA_W-1:0] ch_in   [NUM_CH];
    logic [VOL_W-1:0]  ch_vol  [NUM_CH];
    logic [DATA_W-1:0] ch_out  [NUM_CH];
    logic [MAG_W-1:0]  ch_mag  [NUM_CH];
    logic [MAG_W-1:0]  ch_peak [NUM_CH];
    logic              ch_clr  [NUM_CH];

    // Purpose: map the named stereo ports onto channel-indexed arrays.
    always_comb begin
        ch_in[CH_LEFT]   = in_left;
        ch_in[CH_RIGHT]  = in_right;
        ch_vol[CH_LEFT]  = vol_left;
        ch_vol[CH_RIGHT] = vol_right;
        out_left         = ch_out[CH_LEFT];
        out_right        = ch_out[CH_RIGHT];
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Purpose: a read of this channel clears its peak register.
        always_comb begin
            ch_clr[ch] = rd_req && (rd_sel == 1'(ch));
        end

        abs_sat_mag #(.W(DATA_W)) u_mag (
            .din (ch_in[ch]),
            .mag (ch_mag[ch])
        );

        peak_hold #(.MW(MAG_W)) u_peak (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_vld (in_valid),
            .smp_mag (ch_mag[ch]),
            .clr     (ch_clr[ch]),
            .peak    (ch_peak[ch])
        );

        lin_atten #(.W(DATA_W), .VW(VOL_W)) u_att (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_valid),
            .din   (ch_in[ch]),
            .vol   (ch_vol[ch]),
            .dout  (ch_out[ch])
        );
    end

    // Purpose: output strobe trails the input strobe by one register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Purpose: capture the selected peak before it is cleared, flag the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_peak  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                rd_peak <= ch_peak[rd_sel];
            end
        end
    end
endmodule

// File: rtl/stg_checker.sv
// Module: temporal checks on the stereo volume/peak block, bound to its top.
// Assumes rst_n is driven low from time zero.
module stg_checker #(
    parameter int DATA_W = 24,
    parameter int VOL_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_left,
    input logic [DATA_W-1:0] in_right,
    input logic [VOL_W-1:0]  vol_left,
    input logic [VOL_W-1:0]  vol_right,
    input logic              rd_req,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_left,
    input logic [DATA_W-1:0] out_right,
    input logic              rd_valid
);
    // R1: reset leaves both strobes low
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !rd_valid));

    // R2: output strobe follows input strobe by one cycle
    p_strobe_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_strobe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5: setting 0 is a pass-through on each side
    p_unity_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vol_left == '0) |=> (out_left == $past(in_left)));
    p_unity_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vol_right == '0) |=> (out_right == $past(in_right)));

    // R8: every read request yields a result strobe
    p_read_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R10: outputs hold while no sample arrives
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_left) && $stable(out_right)));
endmodule

bind stereo_gain_peak stg_checker #(.DATA_W(DATA_W), .VOL_W(VOL_W)) u_stg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .vol_left  (vol_left),
    .vol_right (vol_right),
    .rd_req    (rd_req),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .rd_valid  (rd_valid)
);

// File: tb/tb_stereo_gain_peak.sv
module tb_stereo_gain_peak;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 24;
    localparam int VW = 8;
    localparam int MAXMAG = (1 << (DW - 1)) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_left = '0;
    logic [DW-1:0] in_right = '0;
    logic [VW-1:0] vol_left = '0;
    logic [VW-1:0] vol_right = '0;
    logic          rd_req = 1'b0;
    logic          rd_sel = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_left;
    logic [DW-1:0] out_right;
    logic          rd_valid;
    logic [DW-2:0] rd_peak;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stereo_gain_peak #(.DATA_W(DW), .VOL_W(VW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .vol_left(vol_left), .vol_right(vol_right),
        .rd_req(rd_req), .rd_sel(rd_sel),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .rd_valid(rd_valid), .rd_peak(rd_peak)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint expect_att(input longint x, input int v);
        return (x * longint'(256 - v)) >>> 8;
    endfunction

    function automatic longint sx(input logic [DW-1:0] v);
        return longint'($signed(v));
    endfunction

    // Drive one sample pair at a falling edge; results checked one cycle later.
    task automatic send(input longint l, input longint r, input int vl, input int vr);
        in_valid  = 1'b1;
        in_left   = DW'(l);
        in_right  = DW'(r);
        vol_left  = VW'(vl);
        vol_right = VW'(vr);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Issue a read; returns the peak seen in the following cycle.
    task automatic do_read(input bit sel, output longint val);
        rd_req = 1'b1;
        rd_sel = sel;
        @(negedge clk);
        rd_req = 1'b0;
        check("R8 rd_valid", longint'(rd_valid), 1);
        val = longint'(rd_peak);
    endtask

    task automatic t_reset();
        longint v;
        @(negedge clk);
        @(negedge clk);
        check("R1 out_valid", longint'(out_valid), 0);
        check("R1 rd_valid", longint'(rd_valid), 0);
        rst_n = 1'b1;
        do_read(1'b0, v); check("R1 left peak", v, 0);
        do_read(1'b1, v); check("R1 right peak", v, 0);
    endtask

    task automatic t_strobe();
        send(5, 6, 0, 0);
        check("R2 out_valid high", longint'(out_valid), 1);
        @(negedge clk);
        check("R2 out_valid low", longint'(out_valid), 0);
    endtask

    task automatic t_gain();
        longint smp [6] = '{1000, -1000, 8388607, -8388608, -1, 257};
        int     vols [4] = '{0, 1, 128, 255};
        foreach (vols[i]) begin
            foreach (smp[j]) begin
                send(smp[j], -smp[j] - 1, vols[i], vols[i]);
                check("R3 left", sx(out_left), expect_att(smp[j], vols[i]));
                check("R3 right", sx(out_right), expect_att(-smp[j] - 1, vols[i]));
            end
        end
        send(4096, -4096, 0, 255);
        check("R5 unity", sx(out_left), 4096);
        check("R5 max step", sx(out_right), -16);
    endtask

    task automatic t_independent();
        send(25600, 25600, 100, 200);
        check("R4 left uses vol_left", sx(out_left), expect_att(25600, 100));
        check("R4 right uses vol_right", sx(out_right), expect_att(25600, 200));
    endtask

    task automatic t_hold();
        send(-300, 700, 10, 20);
        in_left = DW'(12345); in_right = DW'(-999);
        @(negedge clk);
        @(negedge clk);
        check("R10 left hold", sx(out_left), expect_att(-300, 10));
        check("R10 right hold", sx(out_right), expect_att(700, 20));
    endtask

    task automatic t_peak();
        longint v;
        do_read(1'b0, v); do_read(1'b1, v);
        send(300, -50, 255, 255);
        send(-900, 40, 255, 0);
        send(200, -60, 0, 0);
        do_read(1'b0, v); check("R6 left peak ignores volume", v, 900);
        do_read(1'b0, v); check("R8 left cleared", v, 0);
        do_read(1'b1, v); check("R6 right peak", v, 60);
    endtask

    task automatic t_saturate();
        longint v;
        send(-8388608, 8388607, 0, 0);
        do_read(1'b0, v); check("R7 most negative", v, MAXMAG);
        do_read(1'b1, v); check("R7 most positive", v, MAXMAG);
    endtask

    task automatic t_read_isolation();
        longint v;
        send(77, 88, 0, 0);
        do_read(1'b0, v); check("R8 left value", v, 77);
        do_read(1'b1, v); check("R8 right untouched", v, 88);
    endtask

    task automatic t_collision();
        longint v;
        send(100, 500, 0, 0);
        rd_req = 1'b1; rd_sel = 1'b0;
        in_valid = 1'b1; in_left = DW'(-50); in_right = DW'(20);
        @(negedge clk);
        rd_req = 1'b0; in_valid = 1'b0;
        check("R9 read returns prior", longint'(rd_peak), 100);
        do_read(1'b0, v); check("R9 reload with sample", v, 50);
        do_read(1'b1, v); check("R9 other channel", v, 500);
    endtask

    initial begin
        t_reset();
        t_strobe();
        t_gain();
        t_independent();
        t_hold();
        t_peak();
        t_saturate();
        t_read_isolation();
        t_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule